// File: doc/BRIEF.md
# Four-way decision diagram machine

This block walks a decision diagram that is stored as a program in its own instruction memory. Each step tests two neighbouring input variables at once, and their two-bit value picks one of four full successor addresses. An output step publishes a result word and jumps to a stored address, usually the root of the diagram, so that the next evaluation can start at once. Compared with a machine that tests one variable per step, a path through the diagram needs about half as many steps.

The program is written through a plain word-wide load port. The evaluation advances one instruction on every clock cycle in which the run enable is high, and it freezes in place while the run enable is low. Each terminal that is reached raises a one-cycle valid strobe together with a registered result. The instruction width is not set by hand: it follows from the address width, the number of input pairs and the result width.

Top module: `quad_branch_engine`

## Requirements
- R1: While reset is asserted, the program counter returns to address 0 and both the result and the valid strobe are cleared to zero.
- R2: When `load_en` is high at a rising edge, `load_word` is stored at `load_addr`. Any later fetch from that address executes the new word.
- R3: In every cycle with `run_en` high, exactly one instruction executes. While `run_en` is low, nothing executes, the program counter holds, and `result_valid_o` stays low.
- R4: A word whose top bit is 0 is a branch. Its index field sits directly under the unused pad bits, occupying bits [4A+I-1:4A]. Below it come target 0 at [4A-1:3A], target 1 at [3A-1:2A], target 2 at [2A-1:A] and target 3 at [A-1:0], where A is the address width and I is the index width.
- R5: A branch with index i forms the pair value from `vars_i[2i]` as the most significant bit and `vars_i[2i+1]` as the least significant bit. A pair value v loads target v into the program counter, and every other input bit has no effect.
- R6: A word whose top bit is 1 is an output. Its jump address sits at [A+W-1:W] and its value at [W-1:0], where W is the result width. Executing it loads the value into `result_o`, raises `result_valid_o` and loads the jump address into the program counter, even when that address is not the root.
- R7: `result_valid_o` is high for exactly one cycle after each executed output and is low otherwise. `result_o` keeps its last value until the next output executes.
- R8: A path that crosses k branches before it reaches its output raises `result_valid_o` after exactly k+1 enabled rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write enable for the instruction memory |
| load_addr | input | ADDR_W | Address of the instruction to write |
| load_word | input | WORD_W | Instruction word to write |
| run_en | input | 1 | Executes one instruction per cycle while high |
| vars_i | input | 2*PAIRS | Input variables tested by branch instructions |
| result_o | output | RES_W | Value of the most recently executed output |
| result_valid_o | output | 1 | One-cycle strobe for a new result |

## Verification
The program has a root branch on pair 0 and a second-level branch on pair 3. The inputs drive each of the four values of both pairs. The values 01 and 10 swap if the two bits of a pair are taken in the wrong order, so these cases separate the correct bit order from the swapped one. Vectors with the high pairs set to ones show that bits outside the tested pairs are ignored. One-level and two-level paths separate latencies of 2 and 3 cycles. One output jumps to a second output rather than to the root, which shows that the stored jump address is honoured. Further runs hold `run_en` low with the inputs set, and rewrite an instruction between evaluations.

// File: rtl/quad_branch_engine.sv
module quad_branch_engine #(
  parameter int ADDR_W = 6,
  parameter int PAIRS  = 8,
  parameter int RES_W  = 8,
  localparam int IDX_W  = (PAIRS > 1) ? $clog2(PAIRS) : 1,
  localparam int BR_W   = IDX_W + 4 * ADDR_W,
  localparam int OUT_W  = ADDR_W + RES_W,
  localparam int BODY_W = (BR_W > OUT_W) ? BR_W : OUT_W,
  localparam int WORD_W = 1 + BODY_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [ADDR_W-1:0]  load_addr,
  input  logic [WORD_W-1:0]  load_word,
  input  logic               run_en,
  input  logic [2*PAIRS-1:0] vars_i,
  output logic [RES_W-1:0]   result_o,
  output logic               result_valid_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] prog_mem [DEPTH];
  logic [ADDR_W-1:0] pc;
  logic [WORD_W-1:0] cur_word;
  logic              is_out;
  logic [IDX_W-1:0]  pair_idx;
  logic [1:0]        pair_val;
  logic [ADDR_W-1:0] br_target;

  assign cur_word = prog_mem[pc];
  assign is_out   = cur_word[WORD_W-1];
  assign pair_idx = cur_word[BR_W-1 -: IDX_W];
  assign pair_val = {vars_i[{pair_idx, 1'b0}], vars_i[{pair_idx, 1'b1}]};

  always_comb begin
    case (pair_val)
      2'd0:    br_target = cur_word[4*ADDR_W-1 -: ADDR_W];
      2'd1:    br_target = cur_word[3*ADDR_W-1 -: ADDR_W];
      2'd2:    br_target = cur_word[2*ADDR_W-1 -: ADDR_W];
      default: br_target = cur_word[ADDR_W-1 -: ADDR_W];
    endcase
  end

  always_ff @(posedge clk) begin
    if (load_en) prog_mem[load_addr] <= load_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc             <= '0;
      result_o       <= '0;
      result_valid_o <= 1'b0;
    end else begin
      result_valid_o <= 1'b0;
      if (run_en) begin
        if (is_out) begin
          result_o       <= cur_word[RES_W-1:0];
          result_valid_o <= 1'b1;
          pc             <= cur_word[OUT_W-1 -: ADDR_W];
        end else begin
          pc <= br_target;
        end
      end
    end
  end
endmodule

module quad_branch_engine_chk #(
  parameter int ADDR_W = 6,
  parameter int RES_W  = 8,
  parameter int WORD_W = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic [ADDR_W-1:0] pc,
  input logic [WORD_W-1:0] cur_word,
  input logic [RES_W-1:0]  result_o,
  input logic              result_valid_o
);
  AST_VALID_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> $past(run_en)); // R3

  AST_IDLE_PC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(pc)); // R3

  AST_VALID_FROM_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> $past(cur_word[WORD_W-1])); // R6

  AST_BRANCH_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !cur_word[WORD_W-1]) |=> !result_valid_o); // R7

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid_o |=> (result_valid_o || $stable(result_o))); // R7
endmodule

bind quad_branch_engine quad_branch_engine_chk #(
  .ADDR_W(ADDR_W), .RES_W(RES_W), .WORD_W(WORD_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .pc(pc), .cur_word(cur_word),
  .result_o(result_o), .result_valid_o(result_valid_o)
);

// File: tb/quad_branch_engine_tb_top.sv
module quad_branch_engine_tb_top;
  localparam int A = 6;
  localparam int P = 8;
  localparam int RW = 8;
  localparam int WW = 28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_en = 1'b0;
  logic [A-1:0]  load_addr = '0;
  logic [WW-1:0] load_word = '0;
  logic          run_en = 1'b0;
  logic [2*P-1:0] vars_i = '0;
  logic [RW-1:0] result_o;
  logic          result_valid_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [RW-1:0] exp_q[$];

  always #10 clk = ~clk;

  quad_branch_engine #(.ADDR_W(A), .PAIRS(P), .RES_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_word(load_word), .run_en(run_en), .vars_i(vars_i),
    .result_o(result_o), .result_valid_o(result_valid_o)
  );

  function automatic logic [WW-1:0] mk_br(input int idx, input int t0, input int t1,
                                          input int t2, input int t3);
    return {1'b0, idx[2:0], t0[A-1:0], t1[A-1:0], t2[A-1:0], t3[A-1:0]};
  endfunction

  function automatic logic [WW-1:0] mk_out(input int jmp, input int val);
    return {1'b1, 13'd0, jmp[A-1:0], val[RW-1:0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int addr, input logic [WW-1:0] w);
    @(negedge clk);
    load_en = 1'b1; load_addr = addr[A-1:0]; load_word = w;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && result_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected strobe", result_o, 0);
      end else begin
        logic [RW-1:0] e;
        e = exp_q.pop_front();
        check(result_o == e, "R5/R6 result", result_o, e);
      end
    end
  end

  task automatic run_case(input logic [2*P-1:0] v, input int exp, input int steps,
                          input string req);
    int n;
    @(negedge clk);
    vars_i = v;
    exp_q.push_back(exp[RW-1:0]);
    run_en = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!result_valid_o && n < 12);
    run_en = 1'b0;
    check(n == steps, {req, " R8 latency"}, n, steps);
    @(negedge clk);
    check(result_valid_o == 1'b0, "R7 strobe one cycle", result_valid_o, 0);
    check(result_o == exp[RW-1:0], "R7 result held", result_o, exp);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    load(0,  mk_br(0, 5, 6, 7, 10));
    load(5,  mk_out(0, 8'h11));
    load(6,  mk_out(0, 8'h22));
    load(7,  mk_out(0, 8'h33));
    load(10, mk_br(3, 11, 12, 13, 14));
    load(11, mk_out(0, 8'h40));
    load(12, mk_out(0, 8'h41));
    load(13, mk_out(0, 8'h42));
    load(14, mk_out(20, 8'h43));
    load(20, mk_out(0, 8'h5A));
    repeat (3) @(negedge clk);
    check(result_valid_o == 1'b0, "R1 valid in reset", result_valid_o, 0);
    check(result_o == '0, "R1 result in reset", result_o, 0);
    rst_n = 1'b1;

    // R1: pc starts at the root, pair0=00 goes to address 5
    run_case(16'h0000, 8'h11, 2, "R1 R4 R5 pair 00");
    // R3: idle with inputs set, nothing executes
    vars_i = 16'h0002;
    repeat (5) begin
      @(negedge clk);
      check(result_valid_o == 1'b0, "R3 idle no strobe", result_valid_o, 0);
      check(result_o == 8'h11, "R3 idle result held", result_o, 8'h11);
    end
    run_case(16'h0002, 8'h22, 2, "R5 pair 01");
    run_case(16'h0001, 8'h33, 2, "R5 pair 10");
    run_case(16'hFF02, 8'h22, 2, "R5 other bits ignored");
    run_case(16'h0003, 8'h40, 3, "R5 pair3 00");
    run_case(16'h0083, 8'h41, 3, "R5 pair3 01");
    run_case(16'h0043, 8'h42, 3, "R5 pair3 10");
    run_case(16'h00C3, 8'h43, 3, "R5 pair3 11");
    run_case(16'h0000, 8'h5A, 1, "R6 non-root jump");
    // R2: rewrite a terminal and observe the new value
    load(5, mk_out(0, 8'h77));
    run_case(16'h0000, 8'h77, 2, "R2 reload");
    run_case(16'hFFF0, 8'h77, 2, "R2 R5 high pairs ignored");
    // R1: reset mid-program returns to the root
    @(negedge clk); vars_i = 16'h0003; run_en = 1'b1;
    @(negedge clk); run_en = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check(result_o == '0, "R1 result cleared", result_o, 0);
    run_case(16'h0001, 8'h33, 2, "R1 root after reset");
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule